// File: doc/BRIEF.md
# Random Word Source with Register Front End

This block hands software one 32-bit random word at a time through a small register window of four 32-bit words: a control word, a status word, a write-only entropy word and a read-only output word. Inside sit a 32-bit Galois shift-register engine and a single-entry output holder. Once started, the engine steps every awake cycle. It folds a free-running noise bit into its state and mixes in every value that software writes to the entropy word. After a fixed refill delay the holder captures the engine state.

Each read of the output word empties the holder and starts the next refill. A read that finds the holder empty is an underflow. It returns zero and raises three status flags, and each flag has its own clear rule. It can also drive the error interrupt, and when high assurance is on it latches a security-violation flag that only reset removes. The start and high-assurance controls are one-way: software can set them but cannot clear them. Sleep comes either from a control bit or from an external doze pin. It freezes the refill countdown and the engine.

The refill controller is a four-state machine:
- `FILL_OFF`: not started. It leaves on start (`go`).
- `FILL_RUN`: counting down the refill. It goes to `FILL_PAUSE` on sleep and to `FILL_FULL` when the count completes.
- `FILL_PAUSE`: frozen while asleep. It returns to `FILL_RUN` on wake.
- `FILL_FULL`: the holder is valid. It goes to `FILL_RUN` (or to `FILL_PAUSE` if asleep) when the output word is read.

Top module: `rng_regif`

## Requirements
- R1: After reset, the control word reads 0x00000000, the status word reads 0x00010000 and `err_irq` is low.
- R2: Control bit 0 (start) and bit 1 (high assurance) stay at 1 once written to 1. Writing 0 to them has no effect, and only reset clears them.
- R3: Control bit 2 (interrupt mask) and bit 4 (sleep) read back as written. Control bit 3 (interrupt clear) always reads 0. The entropy word (offset 0x8) always reads 0.
- R4: After the write that sets start, the status level field [15:8] is still 0 in the 32nd cycle after that write and reads 1 from the next cycle on.
- R5: A read of the output word (offset 0xC) while the level is 1 returns the held word, which is never zero. That read leaves the level at 0. The next word delivered differs from it.
- R6: A read of the output word while the level is 0 returns 0 and sets status bit 1 (last read failed), bit 2 (underflow seen) and bit 3 (error pending).
- R7: A read of the status word (offset 0x4) clears bits 1 and 2 and leaves bit 3 unchanged.
- R8: Writing 1 to control bit 3 clears status bit 3.
- R9: `err_irq` is high exactly while status bit 3 is 1 and control bit 2 is 0.
- R10: An underflow with high assurance on sets status bit 0. That bit survives status reads and interrupt clears. Without high assurance, an underflow leaves bit 0 at 0.
- R11: Status bit 4 equals (control bit 4 OR `doze_in`). While asleep the refill does not advance. A valid held word is never replaced until it is read.
- R12: A write to the entropy word changes the sequence of words that follows it.
- R13: When an output read falls in the same cycle as the refill capture, that read counts as an underflow and returns 0, and the captured word is still kept with level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 status, 0x8 entropy, 0xC output |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| noise_in | input | 1 | Free-running noise bit folded into the engine |
| doze_in | input | 1 | External low-power request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Two of this block's functions can fall in the same cycle: the refill capture that makes the held word valid, and a software read of the output word. The bench times an output read to land on the exact edge on which the 32-cycle refill completes. It then expects that read to return 0 and to count as an underflow, with all three underflow flags set in the following status read, while the level field already shows the newly captured word, which a further read returns as non-zero.

// File: rtl/rng_pkg.sv
package rng_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_ENT  = 2'd2;
    localparam logic [1:0] SEL_OUT  = 2'd3;

    localparam logic [WORD_W-1:0] TAP_MASK = 32'h8020_0003;

    typedef enum logic [1:0] {
        FILL_OFF,
        FILL_RUN,
        FILL_PAUSE,
        FILL_FULL
    } fill_state_e;

    function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
        return s[0] ? ((s >> 1) ^ TAP_MASK) : (s >> 1);
    endfunction
endpackage

// File: rtl/rng_engine.sv
module rng_engine
    import rng_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = 32'hB529_7A4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              noise,
    input  logic              mix_en,
    input  logic [WORD_W-1:0] mix_val,
    output logic [WORD_W-1:0] state_o
);
    logic [WORD_W-1:0] st, nxt;

    always_comb begin
        nxt = st;
        if (advance) nxt = lfsr_step(st) ^ {{(WORD_W-1){1'b0}}, noise};
        if (mix_en)  nxt = nxt ^ mix_val;
        if (nxt == '0) nxt = SEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SEED;
        else        st <= nxt;
    end

    assign state_o = st;
endmodule

// File: rtl/rng_fill_fsm.sv
module rng_fill_fsm
    import rng_pkg::*;
#(
    parameter int LAT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic sleep,
    input  logic take,
    output logic load,
    output logic full
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    fill_state_e state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            FILL_OFF: begin
                cnt_n = '0;
                if (go) state_n = FILL_RUN;
            end
            FILL_RUN: begin
                if (sleep) begin
                    state_n = FILL_PAUSE;
                end else if (cnt == LAST) begin
                    state_n = FILL_FULL;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            FILL_PAUSE: begin
                if (!sleep) state_n = FILL_RUN;
            end
            FILL_FULL: begin
                cnt_n = '0;
                if (take) state_n = sleep ? FILL_PAUSE : FILL_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FILL_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        load = (state == FILL_RUN) && !sleep && (cnt == LAST);
        full = (state == FILL_FULL);
    end

    // R11: a valid word stays until it is taken
    assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> full);
    // R11: no progress while asleep in the paused state
    assert_pause_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_PAUSE && sleep) |=> (state == FILL_PAUSE && $stable(cnt)));
    // R4: nothing starts before go
    assert_off_until_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_OFF && !go) |=> (state == FILL_OFF));
endmodule

// File: rtl/rng_regif.sv
module rng_regif
    import rng_pkg::*;
#(
    parameter int REFILL_LAT = 32,
    parameter logic [WORD_W-1:0] SEED = 32'hB529_7A4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              noise_in,
    input  logic              doze_in,
    output logic              err_irq
);
    localparam logic [7:0] HOLD_DEPTH = 8'd1;

    logic c_go, c_ha, c_mask, c_slp;
    logic f_secv, f_lrs, f_oru, f_erri;
    logic [WORD_W-1:0] out_word, eng_word;

    logic aligned, wr_ctrl, wr_ent, rd_stat, rd_out;
    logic sleeping, go_now, load, full, take, underflow;
    logic [1:0] reg_sel;

    assign reg_sel  = bus_addr[3:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ctrl  = bus_sel &  bus_we & aligned & (reg_sel == SEL_CTRL);
    assign wr_ent   = bus_sel &  bus_we & aligned & (reg_sel == SEL_ENT);
    assign rd_stat  = bus_sel & !bus_we & aligned & (reg_sel == SEL_STAT);
    assign rd_out   = bus_sel & !bus_we & aligned & (reg_sel == SEL_OUT);

    assign sleeping  = c_slp | doze_in;
    assign go_now    = c_go | (wr_ctrl & bus_wdata[0]);
    assign take      = rd_out & full;
    assign underflow = rd_out & !full;

    rng_fill_fsm #(.LAT(REFILL_LAT)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_now),
        .sleep (sleeping),
        .take  (take),
        .load  (load),
        .full  (full)
    );

    rng_engine #(.SEED(SEED)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (go_now & !sleeping),
        .noise   (noise_in),
        .mix_en  (wr_ent),
        .mix_val (bus_wdata),
        .state_o (eng_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_go   <= 1'b0;
            c_ha   <= 1'b0;
            c_mask <= 1'b0;
            c_slp  <= 1'b0;
        end else if (wr_ctrl) begin
            c_go   <= c_go | bus_wdata[0];
            c_ha   <= c_ha | bus_wdata[1];
            c_mask <= bus_wdata[2];
            c_slp  <= bus_wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_secv <= 1'b0;
            f_lrs  <= 1'b0;
            f_oru  <= 1'b0;
            f_erri <= 1'b0;
        end else begin
            if (underflow && c_ha) f_secv <= 1'b1;
            if (underflow) begin
                f_lrs <= 1'b1;
                f_oru <= 1'b1;
            end else if (rd_stat) begin
                f_lrs <= 1'b0;
                f_oru <= 1'b0;
            end
            if (underflow)                    f_erri <= 1'b1;
            else if (wr_ctrl && bus_wdata[3]) f_erri <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_word <= '0;
        else if (load) out_word <= eng_word;
        else if (take) out_word <= '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && aligned) begin
            unique case (reg_sel)
                SEL_CTRL: bus_rdata = {27'd0, c_slp, 1'b0, c_mask, c_ha, c_go};
                SEL_STAT: bus_rdata = {8'd0, HOLD_DEPTH, 7'd0, full, 3'd0,
                                       sleeping, f_erri, f_oru, f_lrs, f_secv};
                SEL_ENT:  bus_rdata = '0;
                SEL_OUT:  bus_rdata = full ? out_word : '0;
            endcase
        end
    end

    assign err_irq = f_erri & ~c_mask;

    assert_go_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_go |=> c_go);
    assert_ha_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_ha |=> c_ha);
    assert_secv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        f_secv |=> f_secv);
    assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (bus_rdata == '0));
    assert_underflow_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (f_lrs && f_oru && f_erri));
    assert_word_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (bus_rdata != '0));
endmodule

// File: tb/tb_rng_regif.sv
module tb_rng_regif;
    localparam int LAT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        noise_in = 1'b0;
    logic        doze_in = 1'b0;
    logic        err_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rng_regif #(.REFILL_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .noise_in(noise_in), .doze_in(doze_in), .err_irq(err_irq)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // control write, then expected control readback
    localparam vec_t VEC [6] = '{
        '{8'd3, 32'h0000_0004, 32'h0000_0004},
        '{8'd3, 32'h0000_0008, 32'h0000_0000},
        '{8'd2, 32'h0000_0002, 32'h0000_0002},
        '{8'd2, 32'h0000_0000, 32'h0000_0002},
        '{8'd3, 32'h0000_0010, 32'h0000_0012},
        '{8'd2, 32'h0000_0000, 32'h0000_0002}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_differ(input string tag, input logic [31:0] a, input logic [31:0] b);
        checks++;
        if (a === b) begin
            errors++;
            $display("FAIL %s: actual=%h expected a value other than %h", tag, a, b);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_sel = 1'b0;
        bus_we = 1'b0;
        doze_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, w1, w2;
        do_reset();

        // R1 reset state
        bus_read(4'h0, d); check("R1 control", d, 32'h0);
        bus_read(4'h4, d); check("R1 status", d, 32'h0001_0000);
        check("R1 irq", {31'd0, err_irq}, 32'h0);

        // R2 / R3 control table
        for (int i = 0; i < 6; i++) begin
            bus_write(4'h0, VEC[i].wd);
            bus_read(4'h0, d);
            check($sformatf("R%0d control row %0d", VEC[i].req, i), d, VEC[i].exp);
        end
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, d); check("R3 entropy reads zero", d, 32'h0);

        // R4 refill timing
        do_reset();
        bus_write(4'h0, 32'h1);
        repeat (LAT - 1) @(posedge clk);
        #1;
        bus_read(4'h4, d); check("R4 level still empty", d, 32'h0001_0000);
        bus_read(4'h4, d); check("R4 level valid", d, 32'h0001_0100);

        // R11 no overwrite, R5 consume
        repeat (100) @(posedge clk);
        #1;
        bus_read(4'h4, d); check("R11 word held", d, 32'h0001_0100);
        bus_read(4'hC, w1); check_differ("R5 word nonzero", w1, 32'h0);
        bus_read(4'h4, d); check("R5 level emptied", d, 32'h0001_0000);
        repeat (LAT + 2) @(posedge clk);
        #1;
        bus_read(4'hC, w2); check_differ("R5 next word differs", w2, w1);

        // R6 underflow, R7/R8/R9 flag clearing, R10 negative
        bus_read(4'hC, d); check("R6 underflow returns zero", d, 32'h0);
        check("R9 irq raised", {31'd0, err_irq}, 32'h1);
        bus_read(4'h4, d); check("R6 R10 flags without high assurance", d, 32'h0001_000E);
        bus_read(4'h4, d); check("R7 status read clears", d, 32'h0001_0008);
        bus_write(4'h0, 32'h8);
        check("R8 irq cleared", {31'd0, err_irq}, 32'h0);
        bus_read(4'h4, d); check("R8 error flag cleared", d, 32'h0001_0000);
        bus_write(4'h0, 32'h4);
        bus_read(4'hC, d);
        check("R9 masked irq", {31'd0, err_irq}, 32'h0);
        bus_read(4'h4, d); check("R9 flag set under mask", d, 32'h0001_000E);

        // R10 security violation
        do_reset();
        bus_write(4'h0, 32'h2);
        bus_read(4'hC, d);
        bus_read(4'h4, d); check("R10 violation flagged", d, 32'h0001_000F);
        bus_write(4'h0, 32'h8);
        bus_read(4'h4, d); check("R10 violation sticky", d, 32'h0001_0001);

        // R11 sleep
        do_reset();
        doze_in = 1'b1;
        bus_read(4'h4, d); check("R11 doze reported", d, 32'h0001_0010);
        bus_write(4'h0, 32'h1);
        repeat (100) @(posedge clk);
        #1;
        bus_read(4'h4, d); check("R11 frozen asleep", d, 32'h0001_0010);
        doze_in = 1'b0;
        repeat (LAT + 2) @(posedge clk);
        #1;
        bus_read(4'h4, d); check("R11 refill after wake", d, 32'h0001_0100);
        bus_write(4'h0, 32'h10);
        bus_read(4'h4, d); check("R11 sleep bit reported", d, 32'h0001_0110);

        // R13 coincidence of refill capture and output read
        do_reset();
        bus_write(4'h0, 32'h1);
        repeat (LAT - 1) @(posedge clk);
        #1;
        bus_read(4'hC, d); check("R13 colliding read returns zero", d, 32'h0);
        bus_read(4'h4, d); check("R13 underflow and word kept", d, 32'h0001_010E);
        bus_read(4'hC, d); check_differ("R13 captured word", d, 32'h0);

        // R12 entropy changes the sequence
        do_reset();
        bus_write(4'h0, 32'h1);
        repeat (LAT + 2) @(posedge clk);
        #1;
        bus_read(4'hC, w1);
        do_reset();
        bus_write(4'h8, 32'h5A5A_1234);
        bus_write(4'h0, 32'h1);
        repeat (LAT + 2) @(posedge clk);
        #1;
        bus_read(4'hC, w2);
        check_differ("R12 entropy alters word", w2, w1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule